// File: doc/BRIEF.md
# Byte-to-Word Host Bus Bridge

This bridge lets a host with an 8-bit data path drive a peripheral whose data port is 16 bits wide. Two byte-wide holding registers sit between the buses. One keeps the upper byte of a write until the host supplies the lower byte. The other keeps the upper byte of a read after the peripheral has been strobed. Each peripheral access therefore moves a whole 16-bit word under one strobe, while the host makes two byte accesses. Address bit 0 separates the two: a 1 touches only a holding register, and a 0 starts the real transfer.

The upper address bits select one of the peripheral's functions. On writes there are a control-word load and the first and second halves of a transmit word. On reads there are two receive ports, each with two halves, and the half is given to the peripheral on a select line. Reads and writes share the same address values. A chip-select input qualifies every request. The peripheral strobe stays active for a parameterised number of clocks, so the peripheral sees a pulse of guaranteed minimum length. Writes must send the upper byte first, and reads must fetch the lower byte first.

Top module: `byte_word_bridge`

## Requirements
- R1: After reset, host_done, host_busy, host_rdata_oe, per_wdata_oe and every peripheral strobe are 0, and both holding registers contain 0x00.
- R2: An accepted write with host_addr[0]=1 loads host_wdata into the write holding register, raises no peripheral strobe, and raises host_done in the cycle after acceptance.
- R3: An accepted write with host_addr[0]=0 to a mapped function raises exactly one bit of per_wr_stb for exactly STROBE_CYC consecutive cycles, starting the cycle after acceptance. During those cycles it drives per_wdata = {write holding register, host_wdata} with per_wdata_oe high. host_done rises in the cycle after the last strobe cycle.
- R4: The write function is selected by word index host_addr[ADDR_W-1:1]: index 0 drives per_wr_stb[0] (control word), index 1 drives per_wr_stb[1] (transmit first half), and index 2 drives per_wr_stb[2] (transmit second half).
- R5: An accepted read with host_addr[0]=0 and word index w<4 raises per_rd_stb[w>>1] for STROBE_CYC cycles, with per_half_sel = w[0]. The value on per_rdata in the last strobe cycle is split. Its bits [7:0] appear on host_rdata while host_done is high. Its bits [15:8] go into the read holding register.
- R6: An accepted read with host_addr[0]=1 raises no strobe and returns the read holding register in the cycle after acceptance. Without a fresh low-byte read, repeated reads return the last captured value (0x00 after reset).
- R7: host_rdata_oe is high only while host_done marks the end of a read. per_wdata_oe is high only while a write strobe is active. No read strobe is ever active while per_wdata_oe is high.
- R8: A low-byte access to an unmapped word index (write index ≥3, read index ≥4) raises no strobe and completes in the cycle after acceptance. A read of this kind returns 0x00 and leaves both holding registers unchanged.
- R9: A request made with host_cs low, or while host_busy is high, is ignored: no strobe, no host_done, and no holding register changes.
- R10: host_busy is high exactly during the STROBE_CYC cycles of a peripheral strobe. Requests are accepted only while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Chip select qualifying host_req |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Bit 0 selects the high byte; upper bits give the word index |
| host_wdata | input | 8 | Write byte from the host |
| host_rdata | output | 8 | Read byte to the host |
| host_rdata_oe | output | 1 | Drive enable for host_rdata |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Peripheral strobe in progress |
| per_wdata | output | 16 | Word to the peripheral |
| per_wdata_oe | output | 1 | Drive enable for per_wdata |
| per_rdata | input | 16 | Word from the peripheral |
| per_wr_stb | output | 3 | Write function strobes (control, transmit half 1, half 2) |
| per_rd_stb | output | 2 | Receive port read strobes |
| per_half_sel | output | 1 | Receive half select during a read strobe |

## Verification
The assertions assume that host_req is a single-cycle pulse and that per_rdata holds steady through the last cycle of a read strobe. They also rely on the strobe length counting from a clean reset. The stimulus waits for host_done before starting each access. It keeps per_rdata constant for the whole of each read. It breaks the busy rule on purpose only once, to show that a request arriving mid-strobe is dropped. The reference model follows every accepted access, so the strobe shapes, the data paths and both holding registers are compared on every clock.

// File: rtl/bb_pkg.sv
// Shared constants and types for the byte-to-word bridge.
// Assumes a fixed 8/16-bit byte/word pairing and a fixed function map.
package bb_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int N_WR_FN   = 3;   // control, transmit half 1, transmit half 2
    localparam int N_RD_PORT = 2;   // two receive ports, two halves each

    typedef enum logic {
        BB_IDLE   = 1'b0,
        BB_STROBE = 1'b1
    } bb_state_e;
endpackage

// File: rtl/bb_fn_decode.sv
// Decodes a word index and direction into one-hot function strobes.
// Assumes WIDX_W is wide enough to hold 2*N_RD_PORT word indices.
module bb_fn_decode
    import bb_pkg::*;
#(
    parameter int WIDX_W = 3
) (
    input  logic                 we,
    input  logic [WIDX_W-1:0]    word,
    output logic [N_WR_FN-1:0]   wr_sel,
    output logic [N_RD_PORT-1:0] rd_sel,
    output logic                 half,
    output logic                 mapped
);
    // One write strobe per write function index.
    for (genvar i = 0; i < N_WR_FN; i++) begin : g_wr
        assign wr_sel[i] = we && (word == WIDX_W'(i));
    end

    // Each receive port owns two consecutive word indices.
    for (genvar p = 0; p < N_RD_PORT; p++) begin : g_rd
        assign rd_sel[p] = !we && ((word >> 1) == WIDX_W'(p));
    end

    assign half   = word[0];
    assign mapped = (|wr_sel) || (|rd_sel);
endmodule

// File: rtl/bb_byte_latch.sv
// Loadable holding register with synchronous active-low clear.
// Assumes load is a single-cycle qualifier.
module bb_byte_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d when load is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/bb_strobe_seq.sv
// Times one peripheral strobe of exactly STROBE_CYC cycles.
// Assumes start is only raised while active is low and STROBE_CYC >= 1.
module bb_strobe_seq
    import bb_pkg::*;
#(
    parameter int STROBE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int CNT_W = $clog2(STROBE_CYC + 1);

    bb_state_e       st;
    logic [CNT_W-1:0] cnt;

    assign active = (st == BB_STROBE);
    assign last   = active && (cnt == CNT_W'(STROBE_CYC - 1));

    // Enter the strobe on start and leave it after the final counted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BB_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                BB_IDLE: if (start) begin
                    st  <= BB_STROBE;
                    cnt <= '0;
                end
                BB_STROBE: if (last) st <= BB_IDLE;
                           else      cnt <= cnt + 1'b1;
                default: st <= BB_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/byte_word_bridge.sv
// Byte-to-word bridge top: holds high bytes in two registers so each
// low-byte access moves a full word under one timed strobe.
// Assumes host_req pulses for one cycle and per_rdata is steady at strobe end.
module byte_word_bridge
    import bb_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int STROBE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_cs,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [7:0]           host_wdata,
    output logic [7:0]           host_rdata,
    output logic                 host_rdata_oe,
    output logic                 host_done,
    output logic                 host_busy,
    output logic [15:0]          per_wdata,
    output logic                 per_wdata_oe,
    input  logic [15:0]          per_rdata,
    output logic [2:0]           per_wr_stb,
    output logic [1:0]           per_rd_stb,
    output logic                 per_half_sel
);
    localparam int WIDX_W = ADDR_W - 1;

    logic                 active, last, accept, hi_sel, start;
    logic [WIDX_W-1:0]    word;
    logic [N_WR_FN-1:0]   wr_dec, wr_sel_q;
    logic [N_RD_PORT-1:0] rd_dec, rd_sel_q;
    logic                 half_dec, mapped, half_q, we_q, done_q;
    logic [BYTE_W-1:0]    wr_hi_q, wr_lo_q, rd_hi_q, rdata_q, rdata_d;
    logic                 rdata_ld;

    assign hi_sel = host_addr[0];
    assign word   = host_addr[ADDR_W-1:1];
    assign accept = host_req && host_cs && !active;
    assign start  = accept && !hi_sel && mapped;

    bb_fn_decode #(.WIDX_W(WIDX_W)) u_dec (
        .we(host_we), .word(word), .wr_sel(wr_dec), .rd_sel(rd_dec),
        .half(half_dec), .mapped(mapped)
    );

    bb_strobe_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .active(active), .last(last)
    );

    // Write holding register: loaded by a high-byte write.
    bb_byte_latch #(.W(BYTE_W)) u_wr_hi (
        .clk(clk), .rst_n(rst_n), .load(accept && host_we && hi_sel),
        .d(host_wdata), .q(wr_hi_q)
    );

    // Low byte of a write, held steady for the strobe.
    bb_byte_latch #(.W(BYTE_W)) u_wr_lo (
        .clk(clk), .rst_n(rst_n), .load(accept && host_we && !hi_sel),
        .d(host_wdata), .q(wr_lo_q)
    );

    // Read holding register: captures the peripheral's upper byte on the last strobe cycle.
    bb_byte_latch #(.W(BYTE_W)) u_rd_hi (
        .clk(clk), .rst_n(rst_n), .load(last && !we_q),
        .d(per_rdata[15:8]), .q(rd_hi_q)
    );

    // Select the byte returned to the host.
    always_comb begin
        rdata_ld = (last && !we_q) || (accept && !host_we && (hi_sel || !mapped));
        if (last)        rdata_d = per_rdata[7:0];
        else if (hi_sel) rdata_d = rd_hi_q;
        else             rdata_d = '0;
    end

    bb_byte_latch #(.W(BYTE_W)) u_rdata (
        .clk(clk), .rst_n(rst_n), .load(rdata_ld), .d(rdata_d), .q(rdata_q)
    );

    // Keep the decoded function and direction for the length of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel_q <= '0;
            rd_sel_q <= '0;
            half_q   <= 1'b0;
            we_q     <= 1'b0;
        end else if (accept) begin
            wr_sel_q <= wr_dec;
            rd_sel_q <= rd_dec;
            half_q   <= half_dec;
            we_q     <= host_we;
        end
    end

    // Completion pulse: at once for latch-only or unmapped accesses, else after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (accept && (hi_sel || !mapped)) || last;
    end

    assign host_done     = done_q;
    assign host_busy     = active;
    assign host_rdata    = rdata_q;
    assign host_rdata_oe = done_q && !we_q;
    assign per_wdata     = {wr_hi_q, wr_lo_q};
    assign per_wdata_oe  = active && we_q;
    assign per_wr_stb    = active ? wr_sel_q : '0;
    assign per_rd_stb    = active ? rd_sel_q : '0;
    assign per_half_sel  = active && !we_q && half_q;
endmodule

// File: rtl/byte_word_bridge_chk.sv
// Property checker for byte_word_bridge, attached by bind.
// Assumes single-cycle requests and a clean reset before checking.
module byte_word_bridge_chk #(
    parameter int STROBE_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_done,
    input logic        host_busy,
    input logic        host_rdata_oe,
    input logic [15:0] per_wdata,
    input logic        per_wdata_oe,
    input logic [2:0]  per_wr_stb,
    input logic [1:0]  per_rd_stb
);
    localparam int RUN_W = $clog2(STROBE_CYC + 2);

    logic             any_stb;
    logic [RUN_W-1:0] run;

    assign any_stb = (|per_wr_stb) || (|per_rd_stb);

    // Count the length of the current strobe run.
    always_ff @(posedge clk) begin
        if (!rst_n)       run <= '0;
        else if (any_stb) run <= run + 1'b1;
        else              run <= '0;
    end

    a_r4_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_wr_stb));
    a_r5_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_rd_stb));
    a_r7_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
        per_wdata_oe |-> (per_rd_stb == 2'b00));
    a_r7_wr_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (|per_wr_stb) |-> per_wdata_oe);
    a_r7_rdoe_done: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata_oe |-> host_done);
    a_r10_stb_busy: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> host_busy);
    a_r3_stb_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_stb) |-> (run == RUN_W'(STROBE_CYC)));
    a_r3_done_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_stb) |-> host_done);
    a_r3_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wdata_oe && $past(per_wdata_oe)) |-> $stable(per_wdata));
endmodule

bind byte_word_bridge byte_word_bridge_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_done(host_done), .host_busy(host_busy),
    .host_rdata_oe(host_rdata_oe), .per_wdata(per_wdata),
    .per_wdata_oe(per_wdata_oe), .per_wr_stb(per_wr_stb), .per_rd_stb(per_rd_stb)
);

// File: tb/sim_byte_word_bridge.sv
// Bench: behavioural per-clock reference model plus directed scenarios.
module sim_byte_word_bridge;
    localparam int ADDR_W     = 4;
    localparam int STROBE_CYC = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic              rst_n = 1'b0;
    logic              host_cs = 1'b0, host_req = 1'b0, host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic              host_rdata_oe, host_done, host_busy;
    logic [15:0]       per_wdata, per_rdata;
    logic              per_wdata_oe, per_half_sel;
    logic [2:0]        per_wr_stb;
    logic [1:0]        per_rd_stb;
    logic [15:0]       rx_val = 16'h0000;

    assign per_rdata = rx_val;

    byte_word_bridge #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_req(host_req),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .host_done(host_done), .host_busy(host_busy), .per_wdata(per_wdata),
        .per_wdata_oe(per_wdata_oe), .per_rdata(per_rdata),
        .per_wr_stb(per_wr_stb), .per_rd_stb(per_rd_stb),
        .per_half_sel(per_half_sel)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_en = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference model state, advanced on every rising edge.
    int       m_left = 0, m_word = 0;
    bit       m_done = 0, m_we = 0;
    bit [7:0] m_low = 0, m_ol = 0, m_il = 0, m_rdata = 0;

    always @(posedge clk) begin
        int w;
        bit hi;
        if (!rst_n) begin
            m_left = 0; m_done = 0; m_we = 0; m_word = 0;
            m_low = 0; m_ol = 0; m_il = 0; m_rdata = 0;
        end else begin
            m_done = 0;
            if (m_left > 0) begin
                if (m_left == 1) begin
                    m_done = 1;
                    if (!m_we) begin
                        m_rdata = per_rdata[7:0];
                        m_il    = per_rdata[15:8];
                    end
                end
                m_left--;
            end else if (host_req && host_cs) begin
                w  = int'(host_addr) >> 1;
                hi = host_addr[0];
                m_we = host_we; m_word = w;
                if (hi) begin
                    m_done = 1;
                    if (host_we) m_ol = host_wdata;
                    else         m_rdata = m_il;
                end else if ((host_we && w < 3) || (!host_we && w < 4)) begin
                    m_left = STROBE_CYC;
                    if (host_we) m_low = host_wdata;
                end else begin
                    m_done = 1;
                    if (!host_we) m_rdata = 8'h00;
                end
            end
        end
    end

    // Compare every output against the model, away from the rising edge.
    always @(negedge clk) begin
        logic [2:0] exp_wr;
        logic [1:0] exp_rd;
        exp_wr = (m_left > 0 && m_we)  ? 3'(1 << m_word) : 3'b000;
        exp_rd = (m_left > 0 && !m_we) ? 2'(1 << (m_word >> 1)) : 2'b00;
        if (cmp_en) begin
            chk("R10", "busy", 32'(host_busy), 32'(m_left > 0));
            chk("R4", "wr_stb", 32'(per_wr_stb), 32'(exp_wr));
            chk("R5", "rd_stb", 32'(per_rd_stb), 32'(exp_rd));
            chk("R2", "done", 32'(host_done), 32'(m_done));
            chk("R7", "rdata_oe", 32'(host_rdata_oe), 32'(m_done && !m_we));
            chk("R7", "wdata_oe", 32'(per_wdata_oe), 32'(m_left > 0 && m_we));
            if (per_wdata_oe) chk("R3", "per_wdata", 32'(per_wdata), 32'({m_ol, m_low}));
            if (host_rdata_oe) chk("R6", "host_rdata", 32'(host_rdata), 32'(m_rdata));
            if (exp_rd != 0) chk("R5", "half_sel", 32'(per_half_sel), 32'(m_word & 1));
        end
    end

    // Peripheral log of write strobes.
    logic [15:0] log_val = '0;
    logic [2:0]  log_stb = '0;
    int          wr_cyc = 0;
    always @(negedge clk) begin
        if (|per_wr_stb) begin
            log_val = per_wdata;
            log_stb = per_wr_stb;
            wr_cyc++;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic access(input bit we, input int addr, input logic [7:0] wd,
                          output logic [7:0] got);
        @(negedge clk);
        host_cs = 1; host_req = 1; host_we = we;
        host_addr = ADDR_W'(addr); host_wdata = wd;
        @(negedge clk);
        host_req = 0;
        for (int k = 0; k < 100 && !host_done; k++) @(negedge clk);
        got = host_rdata;
    endtask

    initial begin
        logic [7:0] g;
        int snap;
        repeat (3) @(posedge clk);
        cmp_en = 1;
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "busy after reset", 32'(host_busy), 0);
        chk("R1", "strobes after reset", 32'({per_wr_stb, per_rd_stb}), 0);
        access(0, 1, 8'h00, g);
        chk("R1", "read latch after reset", 32'(g), 32'h00);

        // R2 R3 R4: high byte then low byte, each function
        access(1, 3, 8'hAB, g);
        access(1, 2, 8'hCD, g);
        chk("R3", "word to transmit half 1", 32'(log_val), 32'hABCD);
        chk("R4", "strobe transmit half 1", 32'(log_stb), 32'b010);
        access(1, 1, 8'h12, g);
        access(1, 0, 8'h34, g);
        chk("R3", "word to control", 32'(log_val), 32'h1234);
        chk("R4", "strobe control", 32'(log_stb), 32'b001);
        access(1, 5, 8'h5A, g);
        access(1, 4, 8'hA5, g);
        chk("R4", "strobe transmit half 2", 32'(log_stb), 32'b100);
        access(1, 0, 8'h77, g);
        chk("R2", "write latch persists", 32'(log_val), 32'h5A77);

        // R5 R6: low first, then high from the read holding register
        rx_val = 16'hBEEF;
        access(0, 0, 8'h00, g);
        chk("R5", "rx1 low byte", 32'(g), 32'hEF);
        access(0, 1, 8'h00, g);
        chk("R6", "rx1 high byte", 32'(g), 32'hBE);
        rx_val = 16'h1357;
        access(0, 6, 8'h00, g);
        chk("R5", "rx2 half 1 low byte", 32'(g), 32'h57);
        access(0, 7, 8'h00, g);
        chk("R6", "rx2 high byte", 32'(g), 32'h13);
        access(0, 7, 8'h00, g);
        chk("R6", "repeat high byte", 32'(g), 32'h13);

        // R8: unmapped indices
        rx_val = 16'hFFFF;
        access(0, 8, 8'h00, g);
        chk("R8", "unmapped read", 32'(g), 32'h00);
        access(0, 9, 8'h00, g);
        chk("R8", "read latch untouched", 32'(g), 32'h13);
        snap = wr_cyc;
        access(1, 6, 8'h99, g);
        chk("R8", "no strobe on unmapped write", 32'(wr_cyc), 32'(snap));

        // R9: chip select low
        @(negedge clk);
        host_cs = 0; host_req = 1; host_we = 1; host_addr = 4'd0; host_wdata = 8'h66;
        @(negedge clk);
        host_req = 0;
        repeat (8) @(negedge clk);
        chk("R9", "cs low ignored", 32'(wr_cyc), 32'(snap));

        // R9: request during busy is dropped
        @(negedge clk);
        host_cs = 1; host_req = 1; host_we = 1; host_addr = 4'd0; host_wdata = 8'h10;
        @(negedge clk);
        host_req = 0;
        @(negedge clk);
        chk("R10", "busy during strobe", 32'(host_busy), 1);
        host_req = 1; host_addr = 4'd1; host_wdata = 8'hEE;
        @(negedge clk);
        host_req = 0;
        for (int k = 0; k < 100 && !host_done; k++) @(negedge clk);
        access(1, 0, 8'h01, g);
        chk("R9", "busy request ignored", 32'(log_val), 32'h5A01);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule